// File: doc/BRIEF.md
# I2C Master Event Status and Interrupt Unit

This block collects the per-byte event pulses produced by an I2C master's byte engine and turns them into sticky status flags plus one level-sensitive interrupt request. Four event sources are recorded: the wait point after the eighth data bit, a missing acknowledge sampled on the ninth clock, the data-transfer-end point that follows it, and loss of arbitration. Alongside these it keeps a bus-busy flag that spans a whole transaction from START to STOP, and it mirrors the live SCL and SDA levels through a two-flop synchroniser.

Software reads one status byte and one enable byte. It clears an individual event flag by writing the status byte with that flag's bit at zero, and it selects which latched events may raise the interrupt through the enable byte. Within one byte the engine pulses the wait event first, then the acknowledge-fail event, then data-transfer-end; every flag is latched independently, so all of them remain visible and can be serviced in that order. Dropping the controller enable, or asserting reset, returns every flag and every enable bit to zero.

Top module: `i2c_evt_irq_unit`

## Requirements
- R1: The status byte reads SCL level at bit 7, SDA level at bit 6, bit 5 always zero, bus busy at bit 4, arbitration lost at bit 3, acknowledge fail at bit 2, wait at bit 1 and data-transfer-end at bit 0; after reset with both bus lines high it reads 0xC0.
- R2: A one-cycle event pulse on any of the four sources sets its status bit (bit 3 arbitration, bit 2 acknowledge fail, bit 1 wait, bit 0 transfer end) at the next clock edge, and the bit stays set until cleared.
- R3: A status write with an event bit (bits 3..0) at zero clears that flag at the next edge; an event bit written as one leaves that flag unchanged.
- R4: When an event pulse and a clearing write hit the same flag in one cycle, the flag is set after that edge.
- R5: The enable byte uses bit 3 arbitration, bit 2 acknowledge fail, bit 1 wait and bit 0 transfer end; bits 7..4 read as zero; writing zero masks every source.
- R6: The interrupt output is high exactly when some event flag and its enable bit are both set, in the same cycle that the flag or enable becomes visible on the read ports.
- R7: The busy bit sets on a START pulse, clears on a STOP-complete pulse, favours START if both arrive together, and ignores status writes.
- R8: SCL and SDA levels reach status bits 7 and 6 through two flops: a change appears after the second rising edge, not the first, and status writes do not affect these bits.
- R9: Reset or a low controller enable clears all event flags, the busy bit and the enable byte, and event pulses arriving while disabled are not recorded.
- R10: Changing the transfer-end enable while its flag is set raises or lowers the interrupt without altering the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_enable | input | 1 | Controller enable; low holds all flags and enables at zero |
| ev_wait | input | 1 | Pulse: eighth data bit finished |
| ev_nack | input | 1 | Pulse: no acknowledge on ninth clock |
| ev_dte | input | 1 | Pulse: data transfer end |
| ev_arb_lost | input | 1 | Pulse: arbitration lost |
| start_evt | input | 1 | Pulse: START issued |
| stop_done | input | 1 | Pulse: STOP completed |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| sts_wr | input | 1 | Status byte write strobe |
| sts_wdata | input | 8 | Status write data |
| ien_wr | input | 1 | Enable byte write strobe |
| ien_wdata | input | 8 | Enable write data |
| sts_rdata | output | 8 | Status byte |
| ien_rdata | output | 8 | Enable byte |
| irq | output | 1 | Level interrupt request |

## Verification
On every cycle the checker confirms that an enabled event pulse is recorded, that a write-one leaves a flag alone, that a colliding clear loses to the event, that the interrupt matches the masked flags, that busy follows START and STOP, that the line mirrors lag the pins by two edges and that a disabled controller holds everything at zero. The register layout as seen by software, the exact flag patterns left by a sequence of mixed events and partial clears, and the rejection of writes to the read-only bits can only be shown by the bench's scenarios, which compare the read ports against values worked out from the requirements.

// File: rtl/i2c_evt_pkg.sv
// Package: shared bit positions and sizes for the I2C event status unit.
// Assumes an 8-bit register width and four event sources.
package i2c_evt_pkg;
    localparam int REG_W    = 8;
    localparam int N_EVT    = 4;
    // event flag positions (also used by the enable byte)
    localparam int POS_DTE  = 0;
    localparam int POS_WAIT = 1;
    localparam int POS_NACK = 2;
    localparam int POS_ARB  = 3;
    // other status positions
    localparam int POS_BUSY = 4;
    localparam int POS_SPARE = 5;
    localparam int POS_SDA  = 6;
    localparam int POS_SCL  = 7;
endpackage

// File: rtl/i2c_line_sync.sv
// Module: multi-stage synchroniser for a set of asynchronous line levels.
// Assumes lines idle high; every stage resets to RESET_VAL.
module i2c_line_sync #(
    parameter int LINES     = 2,
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_in,
    output logic [LINES-1:0] sync_out
);
    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_line
            logic [STAGES-1:0] chain;
            // shift the raw level through STAGES flops
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= {STAGES{RESET_VAL}};
                else        chain <= {chain[STAGES-2:0], raw_in[g]};
            end
            assign sync_out[g] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/i2c_evt_flags.sv
// Module: bank of sticky event flags with per-bit write-zero-to-clear.
// Assumes event pulses are one cycle wide; an event beats a same-cycle clear.
module i2c_evt_flags #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_all,
    input  logic [N-1:0] ev,
    input  logic         wr,
    input  logic [N-1:0] wkeep,
    output logic [N-1:0] flags
);
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_flag
            // set on event, clear on write-zero, event has priority
            always_ff @(posedge clk) begin
                if (!rst_n || clr_all)     flags[g] <= 1'b0;
                else if (ev[g])            flags[g] <= 1'b1;
                else if (wr && !wkeep[g])  flags[g] <= 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/i2c_irq_mask.sv
// Module: interrupt enable register and masked OR reduction to one request.
// Assumes the enable register is cleared whenever the controller is disabled.
module i2c_irq_mask #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_all,
    input  logic         wr,
    input  logic [N-1:0] wdata,
    input  logic [N-1:0] flags,
    output logic [N-1:0] enables,
    output logic         irq
);
    // hold the software-written enable bits
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) enables <= '0;
        else if (wr)           enables <= wdata;
    end

    // one request when any enabled flag is set
    always_comb begin
        irq = |(flags & enables);
    end
endmodule

// File: rtl/i2c_evt_irq_unit.sv
// Module: top of the I2C event status and interrupt unit.
// Collects byte-engine events into sticky flags, keeps the bus-busy flag,
// mirrors synchronised SCL/SDA and drives one level interrupt.
// Assumes all strobes and pulses are synchronous to clk.
module i2c_evt_irq_unit
    import i2c_evt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_enable,
    input  logic             ev_wait,
    input  logic             ev_nack,
    input  logic             ev_dte,
    input  logic             ev_arb_lost,
    input  logic             start_evt,
    input  logic             stop_done,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic             sts_wr,
    input  logic [REG_W-1:0] sts_wdata,
    input  logic             ien_wr,
    input  logic [REG_W-1:0] ien_wdata,
    output logic [REG_W-1:0] sts_rdata,
    output logic [REG_W-1:0] ien_rdata,
    output logic             irq
);
    logic             clr_all;
    logic [N_EVT-1:0] ev_vec;
    logic [N_EVT-1:0] flags;
    logic [N_EVT-1:0] enables;
    logic [1:0]       lines_sync;
    logic             busy_q;

    assign clr_all = !ctl_enable;

    // gather event pulses into their flag positions
    always_comb begin
        ev_vec           = '0;
        ev_vec[POS_DTE]  = ev_dte;
        ev_vec[POS_WAIT] = ev_wait;
        ev_vec[POS_NACK] = ev_nack;
        ev_vec[POS_ARB]  = ev_arb_lost;
    end

    i2c_line_sync #(
        .LINES    (2),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(1'b1)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_in  ({scl_in, sda_in}),
        .sync_out(lines_sync)
    );

    i2c_evt_flags #(.N(N_EVT)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_all(clr_all),
        .ev     (ev_vec),
        .wr     (sts_wr),
        .wkeep  (sts_wdata[N_EVT-1:0]),
        .flags  (flags)
    );

    i2c_irq_mask #(.N(N_EVT)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_all(clr_all),
        .wr     (ien_wr),
        .wdata  (ien_wdata[N_EVT-1:0]),
        .flags  (flags),
        .enables(enables),
        .irq    (irq)
    );

    // busy spans START to STOP, START wins a tie
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) busy_q <= 1'b0;
        else if (start_evt)    busy_q <= 1'b1;
        else if (stop_done)    busy_q <= 1'b0;
    end

    // assemble the status byte
    always_comb begin
        sts_rdata              = '0;
        sts_rdata[N_EVT-1:0]   = flags;
        sts_rdata[POS_BUSY]    = busy_q;
        sts_rdata[POS_SPARE]   = 1'b0;
        sts_rdata[POS_SDA]     = lines_sync[0];
        sts_rdata[POS_SCL]     = lines_sync[1];
    end

    // assemble the enable byte
    always_comb begin
        ien_rdata            = '0;
        ien_rdata[N_EVT-1:0] = enables;
    end
endmodule

// File: rtl/i2c_evt_irq_chk.sv
// Module: property checker for i2c_evt_irq_unit, attached by bind.
// Assumes the default two-stage synchroniser.
module i2c_evt_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ctl_enable,
    input logic       ev_wait,
    input logic       ev_nack,
    input logic       ev_dte,
    input logic       ev_arb_lost,
    input logic       start_evt,
    input logic       stop_done,
    input logic       scl_in,
    input logic       sda_in,
    input logic       sts_wr,
    input logic [7:0] sts_wdata,
    input logic       ien_wr,
    input logic [7:0] ien_wdata,
    input logic [7:0] sts_rdata,
    input logic [7:0] ien_rdata,
    input logic       irq
);
    logic [1:0] age;

    // count cycles since reset, saturating at 3
    always_ff @(posedge clk) begin
        if (!rst_n)        age <= 2'd0;
        else if (age != 3) age <= age + 2'd1;
    end

    // R2
    evt_dte_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_enable && ev_dte) |=> sts_rdata[0]);
    // R2
    evt_wait_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_enable && ev_wait) |=> sts_rdata[1]);
    // R4
    evt_nack_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_enable && ev_nack && sts_wr && !sts_wdata[2]) |=> sts_rdata[2]);
    // R2
    evt_arb_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_enable && ev_arb_lost) |=> sts_rdata[3]);
    // R3
    keep_on_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_enable && sts_wr && sts_wdata[0] && !ev_dte)
        |=> sts_rdata[0] == $past(sts_rdata[0]));
    // R3
    clear_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr && !sts_wdata[1] && !ev_wait) |=> !sts_rdata[1]);
    // R6
    irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == |(sts_rdata[3:0] & ien_rdata[3:0]));
    // R7
    busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_enable && start_evt) |=> sts_rdata[4]);
    // R7
    busy_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_done && !start_evt) |=> !sts_rdata[4]);
    // R9
    disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_enable |=> (sts_rdata[4:0] == 5'd0 && ien_rdata == 8'd0));
    // R8
    scl_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 3) |-> sts_rdata[7] == $past(scl_in, 2));
    // R8
    sda_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 3) |-> sts_rdata[6] == $past(sda_in, 2));
    // R1
    spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sts_rdata[5]);
    // R5
    ien_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ien_rdata[7:4] == 4'd0);
endmodule

bind i2c_evt_irq_unit i2c_evt_irq_chk u_chk (.*);

// File: tb/sim_i2c_evt_irq_unit.sv
module sim_i2c_evt_irq_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_enable = 1'b0;
    logic       ev_wait = 1'b0, ev_nack = 1'b0, ev_dte = 1'b0, ev_arb_lost = 1'b0;
    logic       start_evt = 1'b0, stop_done = 1'b0;
    logic       scl_in = 1'b1, sda_in = 1'b1;
    logic       sts_wr = 1'b0, ien_wr = 1'b0;
    logic [7:0] sts_wdata = 8'h00, ien_wdata = 8'h00;
    logic [7:0] sts_rdata, ien_rdata;
    logic       irq;
    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    i2c_evt_irq_unit u0 (.*);

    // {events arb,nack,wait,dte ; write ; keep bits ; expected flags}
    localparam logic [12:0] VEC [10] = '{
        {4'b0001, 1'b0, 4'b0000, 4'b0001},
        {4'b0010, 1'b0, 4'b0000, 4'b0011},
        {4'b0100, 1'b0, 4'b0000, 4'b0111},
        {4'b0000, 1'b1, 4'b1110, 4'b0110},
        {4'b1000, 1'b1, 4'b1011, 4'b1010},
        {4'b0010, 1'b1, 4'b1101, 4'b1010},
        {4'b0000, 1'b1, 4'b0000, 4'b0000},
        {4'b1111, 1'b1, 4'b0000, 4'b1111},
        {4'b0000, 1'b1, 4'b0101, 4'b0101},
        {4'b0000, 1'b0, 4'b0000, 4'b0101}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic idle_pulses();
        ev_wait = 0; ev_nack = 0; ev_dte = 0; ev_arb_lost = 0;
        start_evt = 0; stop_done = 0; sts_wr = 0; ien_wr = 0;
    endtask

    task automatic cyc();
        @(negedge clk);
        idle_pulses();
    endtask

    task automatic wr_ien(input logic [7:0] d);
        ien_wr = 1; ien_wdata = d;
        @(negedge clk);
        idle_pulses();
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1; ctl_enable = 1;
        @(negedge clk);
        // R1 reset state with lines high
        chk("R1 reset status", sts_rdata, 8'hC0);
        chk("R5 reset enables", ien_rdata, 8'h00);
        chk("R6 reset irq", {7'd0, irq}, 8'h00);

        // R5: writing all ones keeps only the four source bits
        wr_ien(8'hFF);
        chk("R5 enable upper bits", ien_rdata, 8'h0F);

        // R2 R3 R4 R6: walk the vector table, SCL/SDA held high
        foreach (VEC[i]) begin
            {ev_arb_lost, ev_nack, ev_wait, ev_dte} = VEC[i][12:9];
            sts_wr = VEC[i][8];
            sts_wdata = {4'hF, VEC[i][7:4]};
            @(negedge clk);
            idle_pulses();
            chk($sformatf("R2/R3/R4 vector %0d", i), sts_rdata, {4'b1100, VEC[i][3:0]});
            chk($sformatf("R6 vector %0d irq", i), {7'd0, irq}, {7'd0, |VEC[i][3:0]});
        end

        // R5 R6: masking, flags are 0101
        wr_ien(8'h0A);
        chk("R6 masked irq low", {7'd0, irq}, 8'h00);
        wr_ien(8'h04);
        chk("R6 nack enabled irq", {7'd0, irq}, 8'h01);
        wr_ien(8'h00);
        chk("R5 zero masks all", {7'd0, irq}, 8'h00);

        // R10: toggle transfer-end enable while flag set
        wr_ien(8'h01);
        chk("R10 dte enabled irq", {7'd0, irq}, 8'h01);
        wr_ien(8'h00);
        chk("R10 dte masked irq", {7'd0, irq}, 8'h00);
        chk("R10 flag untouched", sts_rdata, 8'hC5);

        // R7 busy from START to STOP, writes ignored
        start_evt = 1; cyc();
        chk("R7 busy set", sts_rdata, 8'hD5);
        sts_wr = 1; sts_wdata = 8'h05; cyc();
        chk("R7 busy ignores write", sts_rdata, 8'hD5);
        start_evt = 1; stop_done = 1; cyc();
        chk("R7 start wins tie", sts_rdata[4] ? 8'h01 : 8'h00, 8'h01);
        stop_done = 1; cyc();
        chk("R7 busy cleared", sts_rdata, 8'hC5);

        // R8 two-flop latency and writes ignored
        scl_in = 0; @(negedge clk);
        chk("R8 scl after one edge", sts_rdata, 8'hC5);
        @(negedge clk);
        chk("R8 scl after two edges", sts_rdata, 8'h45);
        sda_in = 0; sts_wr = 1; sts_wdata = 8'hC5; cyc();
        @(negedge clk);
        chk("R8 sda mirror, writes ignored", sts_rdata, 8'h05);
        scl_in = 1; sda_in = 1;
        repeat (2) @(negedge clk);

        // R9 disable clears all, events ignored while low
        wr_ien(8'h0F);
        start_evt = 1; cyc();
        ctl_enable = 0; @(negedge clk);
        chk("R9 disable clears status", sts_rdata, 8'hC0);
        chk("R9 disable clears enables", ien_rdata, 8'h00);
        ev_dte = 1; ev_arb_lost = 1; start_evt = 1; cyc();
        ctl_enable = 1; @(negedge clk);
        chk("R9 events ignored while off", sts_rdata, 8'hC0);

        // R9 reset clears flags
        ev_nack = 1; cyc();
        chk("R2 nack set", sts_rdata, 8'hC4);
        rst_n = 0; @(negedge clk);
        rst_n = 1; @(negedge clk);
        chk("R9 reset clears", sts_rdata, 8'hC0);

        done = 1'b1;
        report();
    end
endmodule